// File: doc/BRIEF.md
# Paged program-memory byte loader

This block carries out byte loads from a program memory organised as 16-bit words, using a 24-bit byte address. The address is an 8-bit page value joined above a 16-bit pointer. Bit 0 of the byte address picks the half of the fetched word. Bits 23..1 form the word address sent to memory. The block recognises three instruction words. The implied form always loads register 0. The explicit form loads a register named by a 5-bit field. The post-increment form loads a named register and then adds one to the full 24-bit page:pointer value.

Instructions arrive on a valid/ready stream. `insn_ready` is high only while the block is idle. An instruction is taken on the first rising edge where `insn_valid` and `insn_ready` are both high. The sender must then hold `insn_valid`, `insn`, `page_in` and `ptr_in` steady until that edge. Once it has taken an instruction, the block spends three cycles on it: the accept cycle, a memory read cycle, and a write cycle. In the write cycle the register write, any address write-back and the PC advance all happen together. The memory answers one cycle after a read request. The register file and the pointer registers cannot push back.

Top module: `xpm_byte_loader`

## Requirements
- R1: The word address sent on `mem_addr` is bits 23..1 of the byte address `{page_in, ptr_in}` captured at acceptance. It is presented with `mem_rd_en` high in the cycle right after the accept edge.
- R2: The written byte is `mem_rdata[7:0]` when byte-address bit 0 is 0, and `mem_rdata[15:8]` when it is 1.
- R3: Word 16'h95D8 writes register 0 and leaves `adr_we` low.
- R4: Words matching 1001_000d_dddd_0110 write register `insn[8:4]` and leave `adr_we` low.
- R5: Words matching 1001_000d_dddd_0111 write register `insn[8:4]` and raise `adr_we`. In that cycle `{page_out, ptr_out}` equals the captured byte address plus one, modulo 2^24, with the carry passing from pointer into page.
- R6: `rf_we` is high exactly two cycles after the accept edge, for one cycle. `insn_ready` is low from the accept edge until the write cycle ends, so instructions are taken at most once every three cycles.
- R7: `undef_flag` is high in the write cycle of a post-increment load whose destination is 30 or 31, and low at every other time.
- R8: A valid word that matches none of the three forms is consumed with no effect: no memory read, no register write, no address write-back, no PC advance, and `insn_ready` stays high.
- R9: While reset is held, and in the first cycle after it, `insn_ready` is high and every strobe (`mem_rd_en`, `rf_we`, `adr_we`, `pc_adv`, `undef_flag`) is low.
- R10: `pc_adv` pulses once per executed load, in its write cycle, and never for an ignored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word is present |
| insn_ready | output | 1 | Block can take an instruction |
| insn | input | 16 | Instruction word |
| page_in | input | 8 | Current page register value |
| ptr_in | input | 16 | Current pointer register value |
| mem_rd_en | output | 1 | Program memory read request |
| mem_addr | output | 23 | Program memory word address |
| mem_rdata | input | 16 | Word returned one cycle after the request |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 5 | Destination register index |
| rf_wdata | output | 8 | Byte to write |
| adr_we | output | 1 | Page and pointer write-back strobe |
| page_out | output | 8 | Incremented page value |
| ptr_out | output | 16 | Incremented pointer value |
| pc_adv | output | 1 | Advance the program counter by one word |
| undef_flag | output | 1 | Result undefined (post-increment into a pointer half) |

## Verification
The assertions assume that a sender facing a low `insn_ready` keeps `insn_valid` high. They also assume that memory data is meaningful only in the cycle after a request. The bench raises valid only from a task that holds it, and holds all the instruction fields, until it has seen the handshake. Its memory model registers its answer from the request of the previous cycle. Post-increment loads into registers 30 and 31 are issued deliberately. For those loads only the flag and the strobes are compared, not the written byte.

// File: rtl/xpl_pkg.sv
package xpl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WRITE} xpl_state_e;
  typedef enum logic [1:0] {F_NONE, F_IMPL, F_EXPL, F_POST} xpl_form_e;

  localparam logic [15:0] OP_IMPLIED   = 16'h95D8;
  localparam logic [6:0]  OP_EXT_HEAD  = 7'b1001000;
  localparam logic [3:0]  OP_EXPL_TAIL = 4'b0110;
  localparam logic [3:0]  OP_POST_TAIL = 4'b0111;
endpackage

// File: rtl/xpl_decode.sv
module xpl_decode
  import xpl_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [15:0]       insn,
  output xpl_form_e         form,
  output logic [REG_AW-1:0] rd
);
  always_comb begin
    form = F_NONE;
    rd   = '0;
    if (insn == OP_IMPLIED) begin
      form = F_IMPL;
    end else if (insn[15:9] == OP_EXT_HEAD) begin
      rd = REG_AW'(insn[8:4]);
      if (insn[3:0] == OP_EXPL_TAIL)      form = F_EXPL;
      else if (insn[3:0] == OP_POST_TAIL) form = F_POST;
    end
  end
endmodule

// File: rtl/xpl_byte_sel.sv
module xpl_byte_sel #(
  parameter int WORD_W = 16,
  localparam int BYTE_W = WORD_W / 2
) (
  input  logic [WORD_W-1:0] word,
  input  logic              hi,
  output logic [BYTE_W-1:0] byte_o
);
  assign byte_o = hi ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];
endmodule

// File: rtl/xpl_addr_inc.sv
module xpl_addr_inc #(
  parameter int W = 24
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  assign y = a + W'(1);
endmodule

// File: rtl/xpm_byte_loader.sv
module xpm_byte_loader
  import xpl_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int PTR_W  = 16,
  parameter int WORD_W = 16,
  parameter int REG_AW = 5,
  localparam int ADDR_W = PAGE_W + PTR_W,
  localparam int MEM_AW = ADDR_W - 1,
  localparam int BYTE_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_valid,
  output logic              insn_ready,
  input  logic [15:0]       insn,
  input  logic [PAGE_W-1:0] page_in,
  input  logic [PTR_W-1:0]  ptr_in,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              rf_we,
  output logic [REG_AW-1:0] rf_waddr,
  output logic [BYTE_W-1:0] rf_wdata,
  output logic              adr_we,
  output logic [PAGE_W-1:0] page_out,
  output logic [PTR_W-1:0]  ptr_out,
  output logic              pc_adv,
  output logic              undef_flag
);
  localparam logic [REG_AW-1:0] PTR_LO_REG = REG_AW'((1 << REG_AW) - 2);

  xpl_state_e        state_q;
  xpl_form_e         form_q, dec_form;
  logic [REG_AW-1:0] rd_q, dec_rd;
  logic [ADDR_W-1:0] addr_q, addr_nx;
  logic              take;

  xpl_decode #(.REG_AW(REG_AW)) u_dec (
    .insn(insn), .form(dec_form), .rd(dec_rd)
  );

  xpl_byte_sel #(.WORD_W(WORD_W)) u_sel (
    .word(mem_rdata), .hi(addr_q[0]), .byte_o(rf_wdata)
  );

  xpl_addr_inc #(.W(ADDR_W)) u_inc (
    .a(addr_q), .y(addr_nx)
  );

  assign insn_ready = (state_q == ST_IDLE);
  assign take       = insn_valid && insn_ready && (dec_form != F_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      form_q  <= F_NONE;
      rd_q    <= '0;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (take) begin
          state_q <= ST_FETCH;
          form_q  <= dec_form;
          rd_q    <= (dec_form == F_IMPL) ? '0 : dec_rd;
          addr_q  <= {page_in, ptr_in};
        end
        ST_FETCH: state_q <= ST_WRITE;
        ST_WRITE: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd_en  = (state_q == ST_FETCH);
  assign mem_addr   = addr_q[ADDR_W-1:1];
  assign rf_we      = (state_q == ST_WRITE);
  assign rf_waddr   = rd_q;
  assign pc_adv     = rf_we;
  assign adr_we     = rf_we && (form_q == F_POST);
  assign {page_out, ptr_out} = addr_nx;
  assign undef_flag = adr_we && (rd_q >= PTR_LO_REG);
endmodule

// File: rtl/xpm_byte_loader_chk.sv
module xpm_byte_loader_chk #(
  parameter int PAGE_W = 8,
  parameter int PTR_W  = 16,
  parameter int REG_AW = 5,
  localparam int ADDR_W = PAGE_W + PTR_W,
  localparam int MEM_AW = ADDR_W - 1
) (
  input logic              clk,
  input logic              rst,
  input logic              insn_valid,
  input logic              insn_ready,
  input logic              mem_rd_en,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              rf_we,
  input logic [REG_AW-1:0] rf_waddr,
  input logic              adr_we,
  input logic [PAGE_W-1:0] page_out,
  input logic [PTR_W-1:0]  ptr_out,
  input logic              pc_adv,
  input logic              undef_flag
);
  logic [ADDR_W-1:0] prev_byte;
  assign prev_byte = {page_out, ptr_out} - ADDR_W'(1);

  // input assumption: a stalled sender keeps valid up
  p_hold_valid_r6: assert property (@(posedge clk) disable iff (rst)
    insn_valid && !insn_ready |=> insn_valid);

  p_fetch_then_write_r6: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> rf_we);

  p_busy_not_ready_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en || rf_we) |-> !insn_ready);

  p_single_write_r6: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> !rf_we);

  p_wb_with_write_r5: assert property (@(posedge clk) disable iff (rst)
    adr_we |-> rf_we);

  p_inc_matches_fetch_r5: assert property (@(posedge clk) disable iff (rst)
    adr_we |-> prev_byte[ADDR_W-1:1] == $past(mem_addr));

  p_undef_scope_r7: assert property (@(posedge clk) disable iff (rst)
    undef_flag |-> adr_we && (rf_waddr >= REG_AW'((1 << REG_AW) - 2)));

  p_pc_once_r10: assert property (@(posedge clk) disable iff (rst)
    pc_adv |-> rf_we && $past(mem_rd_en));

  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> !rf_we && !mem_rd_en && !adr_we && insn_ready);
endmodule

bind xpm_byte_loader xpm_byte_loader_chk #(
  .PAGE_W(PAGE_W), .PTR_W(PTR_W), .REG_AW(REG_AW)
) chk_i (
  .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_ready(insn_ready),
  .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .rf_we(rf_we),
  .rf_waddr(rf_waddr), .adr_we(adr_we), .page_out(page_out),
  .ptr_out(ptr_out), .pc_adv(pc_adv), .undef_flag(undef_flag)
);

// File: tb/xpm_byte_loader_tb_top.sv
`timescale 1ns/1ps
module xpm_byte_loader_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        insn_valid = 0;
  logic        insn_ready;
  logic [15:0] insn = 0;
  logic [7:0]  page_in = 0;
  logic [15:0] ptr_in = 0;
  logic        mem_rd_en;
  logic [22:0] mem_addr;
  logic [15:0] mem_rdata = 0;
  logic        rf_we, adr_we, pc_adv, undef_flag;
  logic [4:0]  rf_waddr;
  logic [7:0]  rf_wdata, page_out;
  logic [15:0] ptr_out;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xpm_byte_loader dut_i (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_ready(insn_ready),
    .insn(insn), .page_in(page_in), .ptr_in(ptr_in),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .adr_we(adr_we), .page_out(page_out), .ptr_out(ptr_out),
    .pc_adv(pc_adv), .undef_flag(undef_flag)
  );

  function automatic logic [15:0] memfn(logic [22:0] w);
    logic [31:0] t = {9'd0, w} * 32'h9E37 + 32'h1234;
    return t[15:0] ^ {w[22:16], 9'd0};
  endfunction

  // memory model: one cycle latency
  always @(posedge clk) mem_rdata <= mem_rd_en ? memfn(mem_addr) : 16'hDEAD;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model, advanced once per cycle at the falling edge
  int          m_phase = 0;   // 0 idle, 1 fetch, 2 write
  int          m_form  = 0;   // 1 implied, 2 explicit, 3 post-increment
  int          m_rd    = 0;
  logic [23:0] m_addr  = 0;

  always @(negedge clk) begin
    if (rst) begin
      m_phase = 0;
      chk(insn_ready == 1 && !mem_rd_en && !rf_we && !adr_we && !pc_adv && !undef_flag,
          "R9", "reset outputs", {insn_ready, mem_rd_en, rf_we, adr_we, pc_adv, undef_flag}, 6'b100000);
    end else if (!done) begin
      logic [15:0] w;
      logic [7:0]  eb;
      logic [23:0] inc;
      bit          post, und;
      w    = memfn(m_addr[23:1]);
      eb   = m_addr[0] ? w[15:8] : w[7:0];
      inc  = m_addr + 24'd1;
      post = (m_phase == 2) && (m_form == 3);
      und  = post && (m_rd >= 30);
      chk(insn_ready == (m_phase == 0), "R6", "insn_ready", insn_ready, m_phase == 0);
      chk(mem_rd_en == (m_phase == 1), "R1", "mem_rd_en", mem_rd_en, m_phase == 1);
      if (m_phase == 1) chk(mem_addr == m_addr[23:1], "R1", "mem_addr", mem_addr, m_addr[23:1]);
      chk(rf_we == (m_phase == 2), "R6", "rf_we", rf_we, m_phase == 2);
      chk(pc_adv == (m_phase == 2), "R10", "pc_adv", pc_adv, m_phase == 2);
      chk(adr_we == post, m_form == 3 ? "R5" : "R4", "adr_we", adr_we, post);
      chk(undef_flag == und, "R7", "undef_flag", undef_flag, und);
      if (m_phase == 2 && !und) begin
        chk(rf_waddr == m_rd, m_form == 1 ? "R3" : "R4", "rf_waddr", rf_waddr, m_rd);
        chk(rf_wdata == eb, "R2", "rf_wdata", rf_wdata, eb);
      end
      if (post) chk({page_out, ptr_out} == inc, "R5", "incremented address", {page_out, ptr_out}, inc);
      // advance to the next cycle
      if (m_phase == 1) m_phase = 2;
      else if (m_phase == 2) m_phase = 0;
      else if (insn_valid) begin
        if (insn == 16'h95D8) begin m_form = 1; m_rd = 0; end
        else if (insn[15:9] == 7'b1001000 && insn[3:0] == 4'h6) begin m_form = 2; m_rd = insn[8:4]; end
        else if (insn[15:9] == 7'b1001000 && insn[3:0] == 4'h7) begin m_form = 3; m_rd = insn[8:4]; end
        else m_form = 0;   // R8: ignored word
        if (m_form != 0) begin m_phase = 1; m_addr = {page_in, ptr_in}; end
      end
    end
  end

  task automatic send(logic [15:0] i, logic [7:0] pg, logic [15:0] pt);
    bit a;
    insn = i; page_in = pg; ptr_in = pt; insn_valid = 1;
    do begin
      @(negedge clk); a = insn_ready;
      @(posedge clk); #1;
    end while (!a);
    insn_valid = 0;
  endtask

  function automatic logic [15:0] expl(int d);  return {7'b1001000, 5'(d), 4'h6}; endfunction
  function automatic logic [15:0] postf(int d); return {7'b1001000, 5'(d), 4'h7}; endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    send(16'h95D8, 8'h05, 16'h1000);          // R3 even byte
    repeat (3) @(posedge clk); #1;
    send(16'h95D8, 8'h05, 16'h1001);          // R2 odd byte
    repeat (3) @(posedge clk); #1;
    send(expl(17), 8'hA0, 16'h3456);          // R4
    send(expl(0), 8'h00, 16'h0001);           // R4 back-to-back (held valid)
    send(postf(4), 8'h12, 16'hFFFF);          // R5 carry into page
    send(postf(29), 8'hFF, 16'hFFFF);         // R5 wrap to zero
    send(postf(30), 8'h01, 16'h0002);         // R7
    send(postf(31), 8'h01, 16'h0003);         // R7
    send(16'h9419, 8'h00, 16'h0000);          // R8 jump word ignored
    send(16'h2400, 8'h00, 16'h0000);          // R8 other word ignored
    send(16'h95D9, 8'h00, 16'h0000);          // R8 near miss ignored
    repeat (4) @(posedge clk); #1;
    for (int k = 0; k < 400; k++) begin
      int sel = $urandom_range(0, 4);
      int d = $urandom_range(0, 31);
      logic [15:0] iw;
      case (sel)
        0: iw = 16'h95D8;
        1: iw = expl(d);
        2, 3: iw = postf(d);
        default: iw = 16'($urandom);
      endcase
      send(iw, 8'($urandom), 16'($urandom));
      repeat ($urandom_range(0, 2)) begin @(posedge clk); #1; end
    end
    repeat (5) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule